// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is a purely combinational integer arithmetic and logic unit. It sits between a register file and a flag register inside an execution stage. Each cycle it takes two operands, a 4-bit operation code, an operand-size select and the current carry flag. From these it produces a result, a strobe saying whether that result should be written back, four status flag values and a per-flag update mask.

All arithmetic operations share one adder, including add, add-with-carry, subtract, subtract-with-borrow, negate, increment, decrement and compare. The adder is fed with true or inverted operands and a selected carry-in. The bitwise operations are AND, OR, XOR, NOT and test, and they use a separate logic path. In byte mode only the low eight operand bits take part. The flags are taken at bit 7 and the upper result bits are forced to zero.

The consumer applies each flag value only where the matching mask bit is set. This is how increment and decrement keep the stored carry and how NOT leaves every flag alone.

Top module: `int_alu`

## Requirements
- R1: Op 0 (add) gives A+B and op 1 (add-with-carry) gives A+B+carry_in, both truncated to the selected width. The carry flag is the unsigned carry out of the top bit at that width.
- R2: The borrowing operations set the carry flag exactly when an unsigned borrow occurs at the selected width. Op 2 (subtract) gives A−B, op 3 (subtract-with-borrow) gives A−B−carry_in and op 7 (compare) gives A−B.
- R3: For arithmetic ops, the overflow flag is set exactly when the true signed result lies outside the two's-complement range of the selected width.
- R4: The zero flag is 1 exactly when the result bits at the selected width are all zero.
- R5: The sign flag equals the result bit at the top of the selected width (bit 7 in byte mode, bit 15 in word mode).
- R6: Op 7 (compare) and op 12 (test, bitwise AND) drive wr_en low and still update all four flags. Compare of 5 and 4 gives result 1 with all four flags clear.
- R7: Op 5 (increment, A+1) and op 6 (decrement, A−1) update the zero, sign and overflow flags. flag_c equals carry_in and mask bit 1 is clear.
- R8: Op 4 (negate) gives 0−A. It sets carry when A is nonzero at the selected width and clears carry when A is zero.
- R9: Ops 8, 9, 10 and 12 (AND, OR, XOR, test) clear carry and overflow. Op 11 (NOT, bitwise inverse of A) drives flag_wr to 0.
- R10: With wide low, operand bits 15:8 have no effect and result bits 15:8 are zero.
- R11: flag_wr bit order is {overflow, sign, carry, zero} with zero in bit 0. It is 4'b1111 for every op except increment and decrement (4'b1101) and NOT (4'b0000). Codes 13 to 15 are reserved: result 0, wr_en low, flag_wr 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 16 | First operand (destination side) |
| opnd_b | input | 16 | Second operand |
| op_sel | input | 4 | Operation code |
| wide | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| carry_in | input | 1 | Current carry flag |
| result | output | 16 | Operation result |
| wr_en | output | 1 | Result write-back strobe |
| flag_z | output | 1 | Zero flag value |
| flag_c | output | 1 | Carry / borrow flag value |
| flag_s | output | 1 | Sign flag value |
| flag_o | output | 1 | Overflow flag value |
| flag_wr | output | 4 | Per-flag update mask {o,s,c,z} |

## Verification
The block holds no state, so a faulty decode or carry-in selection shows up at the ports in the same evaluation as the stimulus. Typical symptoms are a carry flag with the wrong polarity on subtraction, an overflow taken at the wrong bit in byte mode, or a compare that raises wr_en. The bench compares every output against a model that computes unsigned and signed results in wide integers. It uses thousands of seeded random vectors across both widths plus directed edge values at the sign and carry boundaries, so a single mis-wired control bit is exposed within the first few hundred vectors.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_NEG  = 4'd4,
        OP_INC  = 4'd5,
        OP_DEC  = 4'd6,
        OP_CMP  = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_NOT  = 4'd11,
        OP_TEST = 4'd12
    } alu_op_e;

    typedef enum logic [2:0] {
        Y_OPB,
        Y_INV_B,
        Y_INV_A,
        Y_ZERO,
        Y_ONES
    } y_sel_e;

    typedef enum logic [1:0] {
        CI_ZERO,
        CI_ONE,
        CI_CF,
        CI_INV_CF
    } cin_sel_e;

    typedef enum logic [2:0] {
        LF_AND,
        LF_OR,
        LF_XOR,
        LF_NOT,
        LF_ZERO
    } logic_fn_e;

    typedef enum logic [1:0] {
        CM_CARRY,
        CM_BORROW,
        CM_KEEP,
        CM_CLEAR
    } carry_mode_e;

    typedef struct packed {
        logic o;
        logic s;
        logic c;
        logic z;
    } alu_flags_t;

    typedef struct packed {
        logic        x_zero;
        y_sel_e      y_sel;
        cin_sel_e    cin_sel;
        logic        use_logic;
        logic_fn_e   lfn;
        carry_mode_e cmode;
        logic        wr;
        alu_flags_t  fwr;
    } alu_ctrl_t;

    localparam alu_flags_t FW_ALL  = '{o: 1'b1, s: 1'b1, c: 1'b1, z: 1'b1};
    localparam alu_flags_t FW_NOC  = '{o: 1'b1, s: 1'b1, c: 1'b0, z: 1'b1};
    localparam alu_flags_t FW_NONE = '{o: 1'b0, s: 1'b0, c: 1'b0, z: 1'b0};

    function automatic alu_ctrl_t arith_ctrl(input logic xz, input y_sel_e ys,
                                             input cin_sel_e cs, input carry_mode_e cm,
                                             input logic wr, input alu_flags_t fw);
        alu_ctrl_t c;
        c.x_zero    = xz;
        c.y_sel     = ys;
        c.cin_sel   = cs;
        c.use_logic = 1'b0;
        c.lfn       = LF_ZERO;
        c.cmode     = cm;
        c.wr        = wr;
        c.fwr       = fw;
        return c;
    endfunction

    function automatic alu_ctrl_t logic_ctrl(input logic_fn_e fn, input carry_mode_e cm,
                                             input logic wr, input alu_flags_t fw);
        alu_ctrl_t c;
        c.x_zero    = 1'b0;
        c.y_sel     = Y_ZERO;
        c.cin_sel   = CI_ZERO;
        c.use_logic = 1'b1;
        c.lfn       = fn;
        c.cmode     = cm;
        c.wr        = wr;
        c.fwr       = fw;
        return c;
    endfunction

    function automatic alu_ctrl_t decode_op(input logic [3:0] code);
        alu_ctrl_t c;
        case (code)
            OP_ADD:  c = arith_ctrl(1'b0, Y_OPB,   CI_ZERO,   CM_CARRY,  1'b1, FW_ALL);
            OP_ADC:  c = arith_ctrl(1'b0, Y_OPB,   CI_CF,     CM_CARRY,  1'b1, FW_ALL);
            OP_SUB:  c = arith_ctrl(1'b0, Y_INV_B, CI_ONE,    CM_BORROW, 1'b1, FW_ALL);
            OP_SBB:  c = arith_ctrl(1'b0, Y_INV_B, CI_INV_CF, CM_BORROW, 1'b1, FW_ALL);
            OP_NEG:  c = arith_ctrl(1'b1, Y_INV_A, CI_ONE,    CM_BORROW, 1'b1, FW_ALL);
            OP_INC:  c = arith_ctrl(1'b0, Y_ZERO,  CI_ONE,    CM_KEEP,   1'b1, FW_NOC);
            OP_DEC:  c = arith_ctrl(1'b0, Y_ONES,  CI_ZERO,   CM_KEEP,   1'b1, FW_NOC);
            OP_CMP:  c = arith_ctrl(1'b0, Y_INV_B, CI_ONE,    CM_BORROW, 1'b0, FW_ALL);
            OP_AND:  c = logic_ctrl(LF_AND,  CM_CLEAR, 1'b1, FW_ALL);
            OP_OR:   c = logic_ctrl(LF_OR,   CM_CLEAR, 1'b1, FW_ALL);
            OP_XOR:  c = logic_ctrl(LF_XOR,  CM_CLEAR, 1'b1, FW_ALL);
            OP_NOT:  c = logic_ctrl(LF_NOT,  CM_KEEP,  1'b1, FW_NONE);
            OP_TEST: c = logic_ctrl(LF_AND,  CM_CLEAR, 1'b0, FW_ALL);
            default: c = logic_ctrl(LF_ZERO, CM_KEEP,  1'b0, FW_NONE);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub
    import int_alu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] y_in,
    input  logic              cin,
    input  logic              wide,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    localparam int NMSB = NARROW_W - 1;
    localparam int WMSB = DATA_W - 1;

    logic [DATA_W:0]   wsum;
    logic [NARROW_W:0] nsum;
    logic              nov, wov;

    always_comb begin
        wsum = {1'b0, x_in} + {1'b0, y_in} + {{DATA_W{1'b0}}, cin};
        nsum = {1'b0, x_in[NMSB:0]} + {1'b0, y_in[NMSB:0]} + {{NARROW_W{1'b0}}, cin};
        wov  = (x_in[WMSB] == y_in[WMSB]) && (wsum[WMSB] != x_in[WMSB]);
        nov  = (x_in[NMSB] == y_in[NMSB]) && (nsum[NMSB] != x_in[NMSB]);
    end

    generate
        if (DATA_W > NARROW_W) begin : g_split
            always_comb begin
                if (wide) begin
                    sum  = wsum[DATA_W-1:0];
                    cout = wsum[DATA_W];
                    ovf  = wov;
                end else begin
                    sum  = {{(DATA_W-NARROW_W){1'b0}}, nsum[NMSB:0]};
                    cout = nsum[NARROW_W];
                    ovf  = nov;
                end
            end
        end else begin : g_single
            always_comb begin
                sum  = wsum[DATA_W-1:0];
                cout = wsum[DATA_W];
                ovf  = wov | (nov & 1'b0) | (wide & 1'b0) | (|nsum & 1'b0);
            end
        end
    endgenerate

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic_fn_e         fn,
    output logic [DATA_W-1:0] out
);
    always_comb begin
        case (fn)
            LF_AND:  out = a_in & b_in;
            LF_OR:   out = a_in | b_in;
            LF_XOR:  out = a_in ^ b_in;
            LF_NOT:  out = ~a_in;
            default: out = '0;
        endcase
    end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
    import int_alu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] res,
    input  logic              wide,
    input  logic              cout,
    input  logic              ovf_in,
    input  logic              carry_in,
    input  carry_mode_e       cmode,
    input  logic              arith,
    output alu_flags_t        flags
);
    always_comb begin
        if (wide) begin
            flags.z = (res == '0);
            flags.s = res[DATA_W-1];
        end else begin
            flags.z = (res[NARROW_W-1:0] == '0);
            flags.s = res[NARROW_W-1];
        end
        flags.o = arith & ovf_in;
        case (cmode)
            CM_CARRY:  flags.c = cout;
            CM_BORROW: flags.c = ~cout;
            CM_KEEP:   flags.c = carry_in;
            default:   flags.c = 1'b0;
        endcase
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [3:0]        op_sel,
    input  logic              wide,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_s,
    output logic              flag_o,
    output logic [3:0]        flag_wr
);
    localparam int HI_W = DATA_W - NARROW_W;

    alu_ctrl_t         ctrl;
    logic [DATA_W-1:0] a_eff, b_eff;
    logic [DATA_W-1:0] x_op, y_op;
    logic              cin;
    logic [DATA_W-1:0] sum, lres, res;
    logic              cout, ovf;
    alu_flags_t        flags;

    always_comb begin
        ctrl  = decode_op(op_sel);
        a_eff = opnd_a;
        b_eff = opnd_b;
        if (!wide) begin
            a_eff = {{HI_W{1'b0}}, opnd_a[NARROW_W-1:0]};
            b_eff = {{HI_W{1'b0}}, opnd_b[NARROW_W-1:0]};
        end
        x_op = ctrl.x_zero ? '0 : a_eff;
        case (ctrl.y_sel)
            Y_OPB:   y_op = b_eff;
            Y_INV_B: y_op = ~b_eff;
            Y_INV_A: y_op = ~a_eff;
            Y_ONES:  y_op = '1;
            default: y_op = '0;
        endcase
        case (ctrl.cin_sel)
            CI_ONE:    cin = 1'b1;
            CI_CF:     cin = carry_in;
            CI_INV_CF: cin = ~carry_in;
            default:   cin = 1'b0;
        endcase
    end

    int_alu_addsub #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) addsub_i (
        .x_in (x_op),
        .y_in (y_op),
        .cin  (cin),
        .wide (wide),
        .sum  (sum),
        .cout (cout),
        .ovf  (ovf)
    );

    int_alu_logic #(.DATA_W(DATA_W)) logic_i (
        .a_in (a_eff),
        .b_in (b_eff),
        .fn   (ctrl.lfn),
        .out  (lres)
    );

    always_comb begin
        res = ctrl.use_logic ? lres : sum;
        if (!wide) res[DATA_W-1:NARROW_W] = '0;
    end

    int_alu_flags #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) flags_i (
        .res      (res),
        .wide     (wide),
        .cout     (cout),
        .ovf_in   (ovf),
        .carry_in (carry_in),
        .cmode    (ctrl.cmode),
        .arith    (~ctrl.use_logic),
        .flags    (flags)
    );

    assign result  = res;
    assign wr_en   = ctrl.wr;
    assign flag_z  = flags.z;
    assign flag_c  = flags.c;
    assign flag_s  = flags.s;
    assign flag_o  = flags.o;
    assign flag_wr = ctrl.fwr;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input logic [DATA_W-1:0] opnd_a,
    input logic [3:0]        op_sel,
    input logic              wide,
    input logic              carry_in,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic              flag_z,
    input logic              flag_c,
    input logic              flag_s,
    input logic              flag_o,
    input logic [3:0]        flag_wr
);
    logic [NARROW_W-1:0] a_lo;
    assign a_lo = opnd_a[NARROW_W-1:0];

    always_comb begin
        if (op_sel == 4'd7 || op_sel == 4'd12)
            AST_CMP_TEST_NO_WRITE: assert (!wr_en && flag_wr == 4'hF) else $error("compare/test wrote"); // R6
        if (op_sel == 4'd5 || op_sel == 4'd6)
            AST_INCDEC_KEEP_CARRY: assert (flag_c == carry_in && !flag_wr[1]) else $error("inc/dec carry"); // R7
        if (op_sel == 4'd8 || op_sel == 4'd9 || op_sel == 4'd10 || op_sel == 4'd12)
            AST_LOGIC_CLEAR_CO: assert (!flag_c && !flag_o) else $error("logic C/O"); // R9
        if (op_sel == 4'd11)
            AST_NOT_NO_FLAGS: assert (flag_wr == 4'h0) else $error("not flags"); // R9
        if (!wide)
            AST_NARROW_HIGH_ZERO: assert (result[DATA_W-1:NARROW_W] == '0) else $error("narrow hi"); // R10
        AST_SIGN_AT_WIDTH: assert (flag_s == (wide ? result[DATA_W-1] : result[NARROW_W-1])) else $error("sign"); // R5
        AST_ZERO_AT_WIDTH: assert (flag_z == (wide ? (result == '0) : (result[NARROW_W-1:0] == '0))) else $error("zero"); // R4
        if (op_sel == 4'd4 && !wide)
            AST_NEG_CARRY: assert (flag_c == (a_lo != '0)) else $error("neg carry"); // R8
        if (op_sel > 4'd12)
            AST_RESERVED_INERT: assert (!wr_en && flag_wr == 4'h0 && result == '0) else $error("reserved"); // R11
    end
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) chk_i (
    .opnd_a   (opnd_a),
    .op_sel   (op_sel),
    .wide     (wide),
    .carry_in (carry_in),
    .result   (result),
    .wr_en    (wr_en),
    .flag_z   (flag_z),
    .flag_c   (flag_c),
    .flag_s   (flag_s),
    .flag_o   (flag_o),
    .flag_wr  (flag_wr)
);

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic [3:0]  op_sel = '0;
    logic        wide = 1'b1, carry_in = 1'b0;
    logic [15:0] result;
    logic        wr_en, flag_z, flag_c, flag_s, flag_o;
    logic [3:0]  flag_wr;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    int_alu dut_i (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .wide(wide),
        .carry_in(carry_in), .result(result), .wr_en(wr_en), .flag_z(flag_z),
        .flag_c(flag_c), .flag_s(flag_s), .flag_o(flag_o), .flag_wr(flag_wr)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s op=%0d a=%h b=%h wide=%0d cf=%0d actual=%h expected=%h",
                     req, what, op_sel, opnd_a, opnd_b, wide, carry_in, act, exp);
        end
    endtask

    function automatic longint sx(input logic [15:0] v, input bit w);
        return w ? longint'($signed(v)) : longint'($signed(v[7:0]));
    endfunction

    task automatic apply(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                         input bit w, input bit cf);
        longint m, ua, ub, full, sa, sb, sres, maxp;
        bit     c, o, arith, we;
        logic [3:0]  fw;
        logic [15:0] r;
        string  creq;
        @(posedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; wide = w; carry_in = cf;
        @(negedge clk);
        m    = w ? 64'hFFFF : 64'hFF;
        maxp = w ? 32767 : 127;
        ua = a & m; ub = b & m; sa = sx(a, w); sb = sx(b, w);
        arith = 1; c = 0; full = 0; sres = 0; fw = 4'hF; we = 1; creq = "R1";
        case (op)
            4'd0: begin full = ua + ub;      sres = sa + sb;      c = full > m; end
            4'd1: begin full = ua + ub + cf; sres = sa + sb + cf; c = full > m; end
            4'd2: begin full = ua - ub;      sres = sa - sb;      c = ua < ub;  creq = "R2"; end
            4'd3: begin full = ua - ub - cf; sres = sa - sb - cf; c = ua < ub + cf; creq = "R2"; end
            4'd4: begin full = -ua;          sres = -sa;          c = ua != 0;  creq = "R8"; end
            4'd5: begin full = ua + 1;       sres = sa + 1;       c = cf; fw = 4'b1101; creq = "R7"; end
            4'd6: begin full = ua - 1;       sres = sa - 1;       c = cf; fw = 4'b1101; creq = "R7"; end
            4'd7: begin full = ua - ub;      sres = sa - sb;      c = ua < ub; we = 0; creq = "R2"; end
            4'd8: begin full = ua & ub;  arith = 0; creq = "R9"; end
            4'd9: begin full = ua | ub;  arith = 0; creq = "R9"; end
            4'd10: begin full = ua ^ ub; arith = 0; creq = "R9"; end
            4'd11: begin full = ~ua;     arith = 0; c = cf; fw = 4'h0; creq = "R9"; end
            4'd12: begin full = ua & ub; arith = 0; we = 0; creq = "R9"; end
            default: begin full = 0; arith = 0; c = cf; we = 0; fw = 4'h0; creq = "R11"; end
        endcase
        r = 16'(full & m);
        o = arith && (sres > maxp || sres < -maxp - 1);
        chk(w ? "R1" : "R10", "result", int'(result), int'(r));
        chk((op == 4'd7 || op == 4'd12) ? "R6" : "R11", "wr_en", int'(wr_en), int'(we));
        chk("R4", "zero", int'(flag_z), int'(r == 0));
        chk("R5", "sign", int'(flag_s), int'(w ? r[15] : r[7]));
        chk("R3", "overflow", int'(flag_o), int'(o));
        chk(creq, "carry", int'(flag_c), int'(c));
        chk("R11", "flag_wr", int'(flag_wr), int'(fw));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle state after reset: add of zeros
        chk("R4", "idle zero", int'(flag_z), 1);
        chk("R6", "idle wr", int'(wr_en), 1);
        // R6: compare 5 with 4
        apply(4'd7, 16'd5, 16'd4, 1'b1, 1'b0);
        chk("R6", "cmp result", int'(result), 1);
        chk("R6", "cmp flags", int'({flag_o, flag_s, flag_c, flag_z}), 0);
        // directed boundaries
        apply(4'd0, 16'h7FFF, 16'h0001, 1'b1, 1'b0); // R3 signed overflow
        apply(4'd0, 16'h00FF, 16'h0001, 1'b0, 1'b0); // R1 byte carry out
        apply(4'd1, 16'hFFFF, 16'h0000, 1'b1, 1'b1); // R1 adc wrap
        apply(4'd3, 16'h0000, 16'h0000, 1'b0, 1'b1); // R2 sbb borrow
        apply(4'd4, 16'h0080, 16'h0000, 1'b0, 1'b0); // R8 neg most negative
        apply(4'd4, 16'hAB00, 16'h0000, 1'b0, 1'b1); // R8 R10 neg zero byte
        apply(4'd5, 16'h007F, 16'h0000, 1'b0, 1'b1); // R7 inc overflow
        apply(4'd6, 16'h8000, 16'h0000, 1'b1, 1'b0); // R7 dec overflow
        apply(4'd11, 16'h1234, 16'h0000, 1'b1, 1'b1); // R9 not
        apply(4'd12, 16'hF0F0, 16'h0F0F, 1'b1, 1'b1); // R6 test zero
        apply(4'd14, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0); // R11 reserved
        apply(4'd2, 16'hFF10, 16'h2220, 1'b0, 1'b0); // R10 high bits ignored
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (($urandom % 8) == 0) ra = {ra[15], 15'h0};
            if (($urandom % 8) == 0) rb = 16'hFFFF;
            apply(4'($urandom % 16), ra, rb, 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule